// File: doc/BRIEF.md
# Fractional Audio Clock Divider

This block derives a slow audio word or bit clock from a fast reference clock. It does not produce a second clock. It produces a one-cycle enable pulse, `tick_o`, in the reference domain. The average spacing between pulses is I + m/n reference cycles. I is an integer divide value and m/n is a fraction whose numerator and denominator are both programmable. The output rate is therefore f_ref × n / (I × n + m). For example, I = 4, m = 0x0740 and n = 0xFFFF turn a reference of about 49.5 MHz into about 12.288 MHz.

Software programs the block through two 32-bit registers. The fraction register sits at byte address 0x0. The integer register sits at byte address 0x4 and also carries a reload control bit and a spare 4-bit field. Writes only stage values. A new setting takes effect when software raises the reload bit, and software clears that bit again afterwards. The new setting is applied at the end of the current output period, so no short or broken period appears on the output.

The fraction is produced by an error accumulator. At each period start the accumulator adds m. When the sum reaches n, that period is stretched by one reference cycle and n is subtracted from the sum.

Top module: `frac_clk_div`

## Requirements
- R1: After a synchronous reset, both registers read 0x0000_0000 and `tick_o` stays low until a valid setting has been reloaded.
- R2: Address 0x0 stores the numerator m in bits 15:0 and the denominator n in bits 31:16, and reads both back unchanged.
- R3: Address 0x4 stores I in bits 15:0, the reload bit in bit 16 and a spare field in bits 27:24. All other bits read as zero. Other addresses ignore writes and read as zero. The spare field has no effect on the divide ratio.
- R4: Writing either register with the reload bit left at 0 does not change `tick_o`.
- R5: While running, each output period lasts I or I+1 cycles. Over any n consecutive periods counted from a reload, the total length is exactly I×n + m cycles; over k such periods it is k×I + floor(k×m/n) cycles.
- R6: A reload issued while the block is idle produces its first pulse two clock edges after the edge that samples the reload write.
- R7: A reload issued while the block is running takes effect at the next pulse. The accumulator is cleared at that point, and the following period already uses the new I. No period is shorter than the smaller of the old I and the new I.
- R8: A setting is valid only when I ≥ 2, n ≠ 0 and m < n. Reloading an invalid setting stops the pulses after the current period ends, or keeps an idle block idle.
- R9: Only a 0→1 change of the reload bit reloads. Writing the reload bit as 1 while it is already 1 stages values but applies nothing, and clearing the bit applies nothing.
- R10: Period j after a reload is stretched exactly when the running sum of m reaches n. For m = 3 and n = 7 the gaps between pulses are 4,4,5,4,5,4,5 when I = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Byte address for both read and write (0x0 fraction, 0x4 integer) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| tick_o | output | 1 | One-cycle enable at the start of each output period |

## Verification
The embedded properties assume that writes arrive as single-cycle strobes on a synchronous bus. They also assume that software only runs the divider with settings that meet the validity rule. Under those assumptions the accumulator stays below the active denominator and the period counter never exceeds the active I.

The stimulus stays within these assumptions. It writes one register per cycle and always drops the reload bit before raising it again. Invalid settings are reloaded only on purpose, to check that the pulses stop. Everything the bench needs to know is stated in the requirements: the field positions, the reload edge rule and the stretch rule.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    localparam int FIELD_W    = 16;
    localparam int REG_W      = 32;
    localparam int AUX_W      = 4;
    localparam int AUX_LSB    = 24;
    localparam int RELOAD_BIT = 16;
    localparam int MIN_INT    = 2;

    typedef struct packed {
        logic [FIELD_W-1:0] den;
        logic [FIELD_W-1:0] num;
        logic [FIELD_W-1:0] ival;
    } div_cfg_t;

    function automatic logic cfg_ok(div_cfg_t c);
        return (c.ival >= FIELD_W'(MIN_INT)) && (c.den != '0) && (c.num < c.den);
    endfunction

endpackage

// File: rtl/frac_div_regs.sv
module frac_div_regs
    import frac_div_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              load_req,
    output div_cfg_t          load_cfg
);

    localparam logic [ADDR_W-1:0] OFS_FRAC = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_INT  = ADDR_W'(4);

    logic [FIELD_W-1:0] num_q, den_q, ival_q;
    logic               reload_q;
    logic [AUX_W-1:0]   aux_q;
    logic               wr_frac, wr_int;
    logic               unused_bits;

    assign wr_frac     = wr_en && (addr == OFS_FRAC);
    assign wr_int      = wr_en && (addr == OFS_INT);
    assign unused_bits = ^{wr_data[REG_W-1:AUX_LSB+AUX_W], wr_data[AUX_LSB-1:RELOAD_BIT+1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q    <= '0;
            den_q    <= '0;
            ival_q   <= '0;
            reload_q <= 1'b0;
            aux_q    <= '0;
        end else begin
            if (wr_frac) begin
                num_q <= wr_data[FIELD_W-1:0];
                den_q <= wr_data[2*FIELD_W-1:FIELD_W];
            end
            if (wr_int) begin
                ival_q   <= wr_data[FIELD_W-1:0];
                reload_q <= wr_data[RELOAD_BIT];
                aux_q    <= wr_data[AUX_LSB+AUX_W-1:AUX_LSB];
            end
        end
    end

    // A reload request is a 0->1 change of the stored reload bit.
    assign load_req = wr_int && wr_data[RELOAD_BIT] && !reload_q;

    always_comb begin
        load_cfg.den  = den_q;
        load_cfg.num  = num_q;
        load_cfg.ival = wr_data[FIELD_W-1:0];
    end

    always_comb begin
        rd_data = '0;
        if (addr == OFS_FRAC) begin
            rd_data = {den_q, num_q};
        end else if (addr == OFS_INT) begin
            rd_data[FIELD_W-1:0]             = ival_q;
            rd_data[RELOAD_BIT]              = reload_q;
            rd_data[AUX_LSB+AUX_W-1:AUX_LSB] = aux_q;
        end
    end

    p_frac_store_r2: assert property (@(posedge clk) disable iff (rst)
        wr_frac |=> ({den_q, num_q} == $past(wr_data)));

    p_edge_only_r9: assert property (@(posedge clk) disable iff (rst)
        load_req |=> !load_req);

endmodule

// File: rtl/frac_div_engine.sv
module frac_div_engine
    import frac_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_req,
    input  div_cfg_t load_cfg,
    output logic     tick_o
);

    div_cfg_t           pend_cfg_q, cur_cfg_q;
    logic               pend_q, active_q;
    logic [FIELD_W-1:0] cnt_q;
    logic [FIELD_W:0]   acc_q, acc_sum;
    logic               boundary, apply, pend_ok, stretch;

    always_comb begin
        boundary = active_q && (cnt_q == '0);
        apply    = pend_q && (!active_q || boundary);
        pend_ok  = cfg_ok(pend_cfg_q);
        acc_sum  = acc_q + {1'b0, cur_cfg_q.num};
        stretch  = acc_sum >= {1'b0, cur_cfg_q.den};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_cfg_q <= '0;
            cur_cfg_q  <= '0;
            active_q   <= 1'b0;
            cnt_q      <= '0;
            acc_q      <= '0;
        end else begin
            if (apply) begin
                if (pend_ok) begin
                    cur_cfg_q <= pend_cfg_q;
                    if (active_q) begin
                        // Period starting now already uses the new setting; m < n so no stretch.
                        acc_q <= {1'b0, pend_cfg_q.num};
                        cnt_q <= pend_cfg_q.ival - 1'b1;
                    end else begin
                        active_q <= 1'b1;
                        acc_q    <= '0;
                        cnt_q    <= '0;
                    end
                end else begin
                    active_q <= 1'b0;
                    acc_q    <= '0;
                    cnt_q    <= '0;
                end
            end else if (boundary) begin
                acc_q <= stretch ? (acc_sum - {1'b0, cur_cfg_q.den}) : acc_sum;
                cnt_q <= stretch ? cur_cfg_q.ival : (cur_cfg_q.ival - 1'b1);
            end else if (active_q) begin
                cnt_q <= cnt_q - 1'b1;
            end

            if (load_req) begin
                pend_q     <= 1'b1;
                pend_cfg_q <= load_cfg;
            end else if (apply) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign tick_o = boundary;

    p_min_gap_r5: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

    p_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (cnt_q <= cur_cfg_q.ival));

    p_acc_bound_r10: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (acc_q < {1'b0, cur_cfg_q.den}));

    p_start_tick_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(active_q) |-> tick_o);

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import frac_div_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              tick_o
);

    logic     load_req;
    div_cfg_t load_cfg;

    frac_div_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .load_req (load_req),
        .load_cfg (load_cfg)
    );

    frac_div_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .load_req (load_req),
        .load_cfg (load_cfg),
        .tick_o   (tick_o)
    );

endmodule

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tick_o;

    always #10 clk = ~clk;

    frac_clk_div u_frac_clk_div (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .tick_o(tick_o)
    );

    int checks = 0;
    int errors = 0;
    int cyc_n  = 0;
    bit done   = 0;
    int tq[$];

    // Behavioural reference state.
    int mf_num, mf_den, mi_int, mi_rel, mi_aux;
    bit pd; int p_i, p_m, p_n;
    bit run; int wt, ac, c_i, c_m, c_n;

    task automatic model_reset();
        mf_num = 0; mf_den = 0; mi_int = 0; mi_rel = 0; mi_aux = 0;
        pd = 0; p_i = 0; p_m = 0; p_n = 0;
        run = 0; wt = 0; ac = 0; c_i = 0; c_m = 0; c_n = 0;
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] a);
        if (a == 3'd0) return (32'(mf_den) << 16) | 32'(mf_num);
        if (a == 3'd4) return (32'(mi_aux) << 24) | (32'(mi_rel) << 16) | 32'(mi_int);
        return 32'd0;
    endfunction

    task automatic model_step(input logic w, input logic [2:0] a, input logic [31:0] d);
        bit ld, bnd, app;
        int s_i, s_m, s_n;
        ld  = w && (a == 3'd4) && d[16] && (mi_rel == 0);
        s_i = int'(d[15:0]); s_m = mf_num; s_n = mf_den;
        bnd = run && (wt == 0);
        app = pd && (!run || bnd);
        if (app) begin
            if (p_i >= 2 && p_n != 0 && p_m < p_n) begin
                c_i = p_i; c_m = p_m; c_n = p_n;
                if (run) begin ac = p_m; wt = p_i - 1; end
                else begin run = 1; ac = 0; wt = 0; end
            end else begin
                run = 0; ac = 0; wt = 0;
            end
        end else if (bnd) begin
            ac = ac + c_m;
            if (ac >= c_n) begin ac = ac - c_n; wt = c_i; end
            else wt = c_i - 1;
        end else if (run) begin
            wt = wt - 1;
        end
        if (ld) begin pd = 1; p_i = s_i; p_m = s_m; p_n = s_n; end
        else if (app) pd = 0;
        if (w && a == 3'd0) begin mf_num = int'(d[15:0]); mf_den = int'(d[31:16]); end
        if (w && a == 3'd4) begin mi_int = int'(d[15:0]); mi_rel = int'(d[16]); mi_aux = int'(d[27:24]); end
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc_n);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d);
        wr_en = w; addr = a; wr_data = d;
        #1;
        check(tick_o == (run && wt == 0), "R5 tick sequence", tick_o, (run && wt == 0));
        check(rd_data == model_read(a), (a == 3'd0) ? "R2 read" : "R3 read", rd_data, model_read(a));
        if (tick_o) tq.push_back(cyc_n);
        @(posedge clk);
        cyc_n++;
        model_step(w, a, d);
        @(negedge clk);
        wr_en = 1'b0;
        if (cyc_n > 150000 && !done) begin
            done = 1;
            check(0, "watchdog", cyc_n, 150000);
            finish_run();
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, (i % 2) ? 3'd4 : 3'd0, '0);
    endtask

    task automatic collect(input int k);
        while (tq.size() < k) idle(1);
    endtask

    initial begin
        int w0, sum;
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        addr = 3'd0; #1; check(rd_data == 0, "R1 frac after reset", rd_data, 0);
        addr = 3'd4; #1; check(rd_data == 0, "R1 int after reset", rd_data, 0);
        check(tick_o == 0, "R1 tick after reset", tick_o, 0);
        @(negedge clk);
        tq.delete(); idle(10);
        check(tq.size() == 0, "R1 no tick before reload", tq.size(), 0);

        // R2/R3/R4: staging without reload; unstored bits dropped
        cyc(1, 3'd0, 32'h0007_0003);
        cyc(1, 3'd4, 32'h5AFE_0004);
        cyc(1, 3'd2, 32'hFFFF_FFFF);
        addr = 3'd0; #1; check(rd_data == 32'h0007_0003, "R2 fraction fields", rd_data, 32'h0007_0003);
        addr = 3'd4; #1; check(rd_data == 32'h0A00_0004, "R3 integer fields", rd_data, 32'h0A00_0004);
        addr = 3'd2; #1; check(rd_data == 0, "R3 unmapped address", rd_data, 0);
        @(negedge clk);
        tq.delete(); idle(20);
        check(tq.size() == 0, "R4 staged values inert", tq.size(), 0);

        // R6/R10/R5: reload from idle, I=4 m=3 n=7
        tq.delete();
        w0 = cyc_n;
        cyc(1, 3'd4, 32'h5AFF_0004);
        collect(8);
        check(tq[0] == w0 + 2, "R6 first tick latency", tq[0] - w0, 2);
        begin
            int exp_g[7] = '{4, 4, 5, 4, 5, 4, 5};
            for (int i = 0; i < 7; i++)
                check(tq[i+1] - tq[i] == exp_g[i], "R10 stretch pattern", tq[i+1] - tq[i], exp_g[i]);
        end
        check(tq[7] - tq[0] == 31, "R5 n periods total", tq[7] - tq[0], 31);

        // R9: rewrite with reload held at 1, then clear: no change
        cyc(1, 3'd4, 32'h0AFF_0006);
        cyc(1, 3'd4, 32'h0A00_0006);
        tq.delete(); collect(8);
        sum = 0;
        for (int i = 0; i < 7; i++) begin
            check((tq[i+1] - tq[i]) inside {4, 5}, "R9 ratio unchanged", tq[i+1] - tq[i], 4);
            sum += tq[i+1] - tq[i];
        end
        check(sum == 31, "R9 seven periods", sum, 31);

        // R7: reload while running, I=5 m=0 n=1
        cyc(1, 3'd0, 32'h0001_0000);
        tq.delete();
        cyc(1, 3'd4, 32'h0001_0005);
        collect(7);
        for (int i = 0; i < 6; i++)
            check(tq[i+1] - tq[i] >= 4, "R7 no short period", tq[i+1] - tq[i], 4);
        for (int i = 2; i < 6; i++)
            check(tq[i+1] - tq[i] == 5, "R7 new ratio", tq[i+1] - tq[i], 5);
        cyc(1, 3'd4, 32'h0000_0005);

        // R8: invalid settings stop or keep idle
        cyc(1, 3'd4, 32'h0001_0001);
        idle(12);
        tq.delete(); idle(40);
        check(tq.size() == 0, "R8 I below two stops", tq.size(), 0);
        cyc(1, 3'd4, 32'h0000_0001);
        cyc(1, 3'd0, 32'h0003_0005);
        cyc(1, 3'd4, 32'h0001_0004);
        tq.delete(); idle(40);
        check(tq.size() == 0, "R8 m not below n", tq.size(), 0);
        cyc(1, 3'd4, 32'h0000_0004);
        cyc(1, 3'd0, 32'h0000_0001);
        cyc(1, 3'd4, 32'h0001_0004);
        tq.delete(); idle(40);
        check(tq.size() == 0, "R8 zero denominator", tq.size(), 0);
        cyc(1, 3'd4, 32'h0000_0004);

        // R5/R3: worked case with spare field set, 1000 periods
        cyc(1, 3'd0, 32'hFFFF_0740);
        tq.delete();
        cyc(1, 3'd4, 32'h0F01_0004);
        collect(1001);
        check(tq[1000] - tq[0] == 4028, "R5 worked case length", tq[1000] - tq[0], 4028);
        check(tq[1] - tq[0] == 4, "R3 spare field inert", tq[1] - tq[0], 4);

        done = 1;
        finish_run();
    end

endmodule